// File: doc/BRIEF.md
# Single-precision floating-point adder

This block adds or subtracts two 32-bit binary floating-point values and returns a correctly rounded 32-bit result together with four exception flags. An operation is offered on a valid/ready input handshake. It carries both operands, an add/subtract select and a 2-bit rounding-mode code. The result leaves on a valid/ready output.

Operands use a sign in bit 31, an 8-bit biased exponent (bias 127) in bits 30..23 and a 23-bit fraction in bits 22..0. A hidden leading 1 is present when the exponent field is nonzero. An all-zero exponent field marks zero, or a subnormal with a hidden 0 and scale 2^-126. An all-ones exponent field marks infinity (zero fraction) or NaN (nonzero fraction). A NaN whose fraction MSB is 0 is signalling.

Internally the block works in four steps:
- It orders the operands by magnitude.
- It shifts the smaller significand right with guard, round and sticky bits.
- It adds or subtracts the significands and normalises, with the left shift clamped so that small results become subnormal.
- It rounds by adding the increment to the packed exponent/fraction word.

It is a two-stage pipeline with a single stall enable.

Top module: `fpadd_sp`

## Requirements
- R1: An operation accepted on a rising edge (in_valid and in_ready both high) appears on out_valid two rising edges later when the output is not stalled. in_ready is high whenever the output slot is empty or being accepted.
- R2: Under mode code 00 (round to nearest, ties to even), finite normal operands give the correctly rounded sum or difference. Examples: 0x40200000 + 0x40500000 = 0x40B80000 (5.75), and 0x3D4CCCCD + 0x3D4CCCCD = 0x3DCCCCCD (nearest value to 0.1).
- R3: Mode code 01 rounds toward zero, 10 toward minus infinity and 11 toward plus infinity. Any discarded nonzero bits set out_flags[0] (inexact).
- R4: An exact halfway case under mode 00 picks the neighbour whose fraction LSB is 0. So 0x3F800000 + 0x33800000 = 0x3F800000 and 0x3F800001 + 0x33800000 = 0x3F800002, both inexact.
- R5: An operand whose exponent lies far below the other affects only the sticky bit. 0x7F000000 + 0x3F800000 gives 0x7F000000 under mode 00 and 0x7F000001 under mode 11.
- R6: Subnormal operands are used at full value, and subnormal results are produced exactly. out_flags[1] (underflow) is set exactly when the result is a nonzero subnormal.
- R7: An exact zero from operands of opposite effective sign is +0 in modes 00, 01 and 11 and -0 in mode 10. Two zeros of the same effective sign keep that sign.
- R8: A rounded result beyond the largest finite magnitude sets out_flags[2] (overflow) and out_flags[0]. It becomes infinity when the mode rounds away from zero in the result's direction (mode 00 always), and 0x7F7FFFFF with the result's sign otherwise.
- R9: Any NaN operand returns 0x7FC00000. out_flags[3] (invalid) is set for a signalling NaN operand and for infinities of opposite effective sign, which also return 0x7FC00000.
- R10: An infinite operand with a finite one, or two infinities of the same effective sign, returns that signed infinity with no flags.
- R11: While out_valid is high and out_ready low, out_valid, out_res and out_flags hold, and in_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The block takes the offered operation this edge |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| in_sub | input | 1 | 1 subtracts in_b from in_a, 0 adds |
| in_rmode | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 down, 11 up |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result this edge |
| out_res | output | 32 | Rounded result |
| out_flags | output | 4 | {invalid, overflow, underflow, inexact} |

## Verification
A grid of 16 boundary encodings is crossed with itself, both operations and all four modes. The encodings are signed zeros, the smallest and largest subnormals, the smallest normal, one, one plus an ulp, a half-ulp value, the largest finite values, both infinities, a quiet and a signalling NaN. The grid separates cancellation signs, the subnormal boundary, overflow saturation by mode and special-value priority. Random operand pairs with nearby exponents exercise alignment shifts of a few bits and massive cancellation, where normalisation distance and the guard bit decide the result. Unrelated random pairs exercise the far-shift sticky path. Directed cases pin the tie-breaking, the check constants and the stall behaviour, including an operation offered while the output is held.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

   typedef enum logic [1:0] {
      RM_NEAR = 2'b00,
      RM_ZERO = 2'b01,
      RM_DOWN = 2'b10,
      RM_UP   = 2'b11
   } rmode_e;

   typedef struct packed {
      logic invalid;
      logic overflow;
      logic underflow;
      logic inexact;
   } fflags_t;

   // guard, round and sticky positions below the significand
   localparam int GRS_W = 3;

endpackage

// File: rtl/fpadd_align.sv
module fpadd_align #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0]          op_a,
   input  logic [EXP_W+FRAC_W:0]          op_b,
   input  logic                           sub,
   output logic                           big_sign,
   output logic [EXP_W-1:0]               big_exp,
   output logic                           eff_sub,
   output logic [FRAC_W+fpadd_pkg::GRS_W:0] big_sig,
   output logic [FRAC_W+fpadd_pkg::GRS_W:0] small_sig,
   output logic                           spec_nan,
   output logic                           spec_inf,
   output logic                           spec_sign,
   output logic                           spec_invalid
);
   import fpadd_pkg::*;

   localparam int DATA_W = 1 + EXP_W + FRAC_W;
   localparam int SIG_W  = FRAC_W + 1;
   localparam int SIG_X  = SIG_W + GRS_W;

   logic [EXP_W-1:0]  ea, eb, e_big_f, e_small_f, ee_big, ee_small, diff, shamt;
   logic [FRAC_W-1:0] fa, fb;
   logic              sa, sb, swap;
   logic              a_nan, b_nan, a_snan, b_snan, a_inf, b_inf;
   logic [DATA_W-2:0] mag_big, mag_small;
   logic [SIG_W-1:0]  sig_b, sig_s;
   logic [2*SIG_X-1:0] wide;

   assign sa = op_a[DATA_W-1];
   assign sb = op_b[DATA_W-1] ^ sub;
   assign ea = op_a[DATA_W-2:FRAC_W];
   assign eb = op_b[DATA_W-2:FRAC_W];
   assign fa = op_a[FRAC_W-1:0];
   assign fb = op_b[FRAC_W-1:0];

   assign a_nan  = (&ea) & (|fa);
   assign b_nan  = (&eb) & (|fb);
   assign a_snan = a_nan & ~fa[FRAC_W-1];
   assign b_snan = b_nan & ~fb[FRAC_W-1];
   assign a_inf  = (&ea) & ~(|fa);
   assign b_inf  = (&eb) & ~(|fb);

   // magnitude order follows the encoding order for finite values
   assign swap      = op_b[DATA_W-2:0] > op_a[DATA_W-2:0];
   assign mag_big   = swap ? op_b[DATA_W-2:0] : op_a[DATA_W-2:0];
   assign mag_small = swap ? op_a[DATA_W-2:0] : op_b[DATA_W-2:0];
   assign e_big_f   = mag_big[DATA_W-2:FRAC_W];
   assign e_small_f = mag_small[DATA_W-2:FRAC_W];
   assign ee_big    = (e_big_f == '0) ? EXP_W'(1) : e_big_f;
   assign ee_small  = (e_small_f == '0) ? EXP_W'(1) : e_small_f;
   assign sig_b     = {|e_big_f, mag_big[FRAC_W-1:0]};
   assign sig_s     = {|e_small_f, mag_small[FRAC_W-1:0]};

   assign diff  = ee_big - ee_small;
   assign shamt = (diff > EXP_W'(SIG_X)) ? EXP_W'(SIG_X) : diff;
   assign wide  = {sig_s, {GRS_W{1'b0}}, {SIG_X{1'b0}}} >> shamt;

   assign big_sig   = {sig_b, {GRS_W{1'b0}}};
   assign small_sig = wide[2*SIG_X-1:SIG_X] | {{(SIG_X-1){1'b0}}, |wide[SIG_X-1:0]};
   assign big_exp   = ee_big;
   assign big_sign  = swap ? sb : sa;
   assign eff_sub   = sa ^ sb;

   assign spec_nan     = a_nan | b_nan | (a_inf & b_inf & (sa ^ sb));
   assign spec_invalid = a_snan | b_snan | (a_inf & b_inf & (sa ^ sb));
   assign spec_inf     = a_inf | b_inf;
   assign spec_sign    = a_inf ? sa : sb;

endmodule

// File: rtl/fpadd_addnorm.sv
module fpadd_addnorm #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W-1:0]                 big_exp,
   input  logic                             eff_sub,
   input  logic [FRAC_W+fpadd_pkg::GRS_W:0] big_sig,
   input  logic [FRAC_W+fpadd_pkg::GRS_W:0] small_sig,
   output logic [FRAC_W+fpadd_pkg::GRS_W:0] norm_sig,
   output logic [EXP_W:0]                   norm_exp,
   output logic                             sum_zero
);
   import fpadd_pkg::*;

   localparam int SIG_X = FRAC_W + 1 + GRS_W;

   logic [SIG_X:0]   sum;
   logic [EXP_W-1:0] lz, limit, shl;

   assign sum = eff_sub ? ({1'b0, big_sig} - {1'b0, small_sig})
                        : ({1'b0, big_sig} + {1'b0, small_sig});

   always_comb begin
      lz = EXP_W'(SIG_X);
      for (int i = 0; i < SIG_X; i++) begin
         if (sum[i]) lz = EXP_W'(SIG_X - 1 - i);
      end
   end

   // never normalise below the smallest normal exponent
   assign limit = big_exp - EXP_W'(1);
   assign shl   = (lz > limit) ? limit : lz;

   always_comb begin
      if (sum[SIG_X]) begin
         norm_sig = sum[SIG_X:1] | {{(SIG_X-1){1'b0}}, sum[0]};
         norm_exp = {1'b0, big_exp} + (EXP_W+1)'(1);
      end else begin
         norm_sig = sum[SIG_X-1:0] << shl;
         norm_exp = {1'b0, big_exp} - {1'b0, shl};
      end
   end

   assign sum_zero = (sum == '0);

endmodule

// File: rtl/fpadd_round.sv
module fpadd_round #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic                             sign,
   input  logic                             eff_sub,
   input  logic [1:0]                       rmode,
   input  logic [FRAC_W+fpadd_pkg::GRS_W:0] norm_sig,
   input  logic [EXP_W:0]                   norm_exp,
   input  logic                             sum_zero,
   input  logic                             spec_nan,
   input  logic                             spec_inf,
   input  logic                             spec_sign,
   input  logic                             spec_invalid,
   output logic [EXP_W+FRAC_W:0]            res,
   output fpadd_pkg::fflags_t               flags
);
   import fpadd_pkg::*;

   localparam int SIG_X  = FRAC_W + 1 + GRS_W;
   localparam int PK_W   = EXP_W + FRAC_W + 1;
   localparam logic [EXP_W-1:0] EXP_ONES = '1;

   rmode_e            rm;
   logic              guard, rnd, stk, lsb, lost, up, ovf, to_inf, zsign;
   logic [EXP_W:0]    exp_pre;
   logic [PK_W-1:0]   packed_w;
   logic [FRAC_W-1:0] frac;

   assign rm    = rmode_e'(rmode);
   assign frac  = norm_sig[SIG_X-2:GRS_W];
   assign lsb   = norm_sig[GRS_W];
   assign guard = norm_sig[2];
   assign rnd   = norm_sig[1];
   assign stk   = norm_sig[0];
   assign lost  = guard | rnd | stk;

   always_comb begin
      unique case (rm)
         RM_NEAR: up = guard & (rnd | stk | lsb);
         RM_ZERO: up = 1'b0;
         RM_DOWN: up = sign & lost;
         RM_UP:   up = ~sign & lost;
      endcase
   end

   // a subnormal pattern packs with a zero exponent field; the increment
   // carries into the exponent on its own
   assign exp_pre  = norm_sig[SIG_X-1] ? norm_exp : '0;
   assign packed_w = {exp_pre, frac} + PK_W'(up);
   assign ovf      = packed_w[PK_W-1:FRAC_W] >= {1'b0, EXP_ONES};
   assign to_inf   = (rm == RM_NEAR) | ((rm == RM_UP) & ~sign) | ((rm == RM_DOWN) & sign);
   assign zsign    = eff_sub ? (rm == RM_DOWN) : sign;

   always_comb begin
      flags = '0;
      if (spec_nan) begin
         res           = {1'b0, EXP_ONES, 1'b1, {(FRAC_W-1){1'b0}}};
         flags.invalid = spec_invalid;
      end else if (spec_inf) begin
         res = {spec_sign, EXP_ONES, {FRAC_W{1'b0}}};
      end else if (sum_zero) begin
         res = {zsign, {(EXP_W+FRAC_W){1'b0}}};
      end else if (ovf) begin
         flags.overflow = 1'b1;
         flags.inexact  = 1'b1;
         res = to_inf ? {sign, EXP_ONES, {FRAC_W{1'b0}}}
                      : {sign, EXP_ONES - EXP_W'(1), {FRAC_W{1'b1}}};
      end else begin
         res             = {sign, packed_w[PK_W-2:0]};
         flags.inexact   = lost;
         flags.underflow = (packed_w[PK_W-2:FRAC_W] == '0);
      end
   end

endmodule

// File: rtl/fpadd_sp.sv
module fpadd_sp #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [EXP_W+FRAC_W:0]   in_a,
   input  logic [EXP_W+FRAC_W:0]   in_b,
   input  logic                    in_sub,
   input  logic [1:0]              in_rmode,
   output logic                    out_valid,
   input  logic                    out_ready,
   output logic [EXP_W+FRAC_W:0]   out_res,
   output logic [3:0]              out_flags
);
   import fpadd_pkg::*;

   localparam int DATA_W = 1 + EXP_W + FRAC_W;
   localparam int SIG_X  = FRAC_W + 1 + GRS_W;

   generate
      if (EXP_W < 3) begin : g_bad_exp
         $error("fpadd_sp: EXP_W must be at least 3");
      end
      if (FRAC_W < 2) begin : g_bad_frac
         $error("fpadd_sp: FRAC_W must be at least 2");
      end
      if ((2 ** EXP_W) <= SIG_X + 1) begin : g_bad_ratio
         $error("fpadd_sp: exponent range too small for the alignment clamp");
      end
   endgenerate

   logic advance;
   assign advance  = ~out_valid | out_ready;
   assign in_ready = advance;

   // stage 0 combinational
   logic             a_sign, a_effsub, a_nan, a_inf, a_isign, a_inv;
   logic [EXP_W-1:0] a_exp;
   logic [SIG_X-1:0] a_big, a_small;

   fpadd_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
      .op_a(in_a), .op_b(in_b), .sub(in_sub),
      .big_sign(a_sign), .big_exp(a_exp), .eff_sub(a_effsub),
      .big_sig(a_big), .small_sig(a_small),
      .spec_nan(a_nan), .spec_inf(a_inf), .spec_sign(a_isign), .spec_invalid(a_inv)
   );

   // stage 1 registers
   logic             s1_valid, s1_sign, s1_effsub, s1_nan, s1_inf, s1_isign, s1_inv;
   logic [EXP_W-1:0] s1_exp;
   logic [SIG_X-1:0] s1_big, s1_small;
   logic [1:0]       s1_rm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid  <= 1'b0;
         s1_sign   <= 1'b0;
         s1_effsub <= 1'b0;
         s1_nan    <= 1'b0;
         s1_inf    <= 1'b0;
         s1_isign  <= 1'b0;
         s1_inv    <= 1'b0;
         s1_exp    <= '0;
         s1_big    <= '0;
         s1_small  <= '0;
         s1_rm     <= '0;
      end else if (advance) begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_sign   <= a_sign;
            s1_effsub <= a_effsub;
            s1_nan    <= a_nan;
            s1_inf    <= a_inf;
            s1_isign  <= a_isign;
            s1_inv    <= a_inv;
            s1_exp    <= a_exp;
            s1_big    <= a_big;
            s1_small  <= a_small;
            s1_rm     <= in_rmode;
         end
      end
   end

   // stage 1 combinational
   logic [SIG_X-1:0]  n_sig;
   logic [EXP_W:0]    n_exp;
   logic              n_zero;
   logic [DATA_W-1:0] r_res;
   fflags_t           r_flags;

   fpadd_addnorm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_addnorm (
      .big_exp(s1_exp), .eff_sub(s1_effsub),
      .big_sig(s1_big), .small_sig(s1_small),
      .norm_sig(n_sig), .norm_exp(n_exp), .sum_zero(n_zero)
   );

   fpadd_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
      .sign(s1_sign), .eff_sub(s1_effsub), .rmode(s1_rm),
      .norm_sig(n_sig), .norm_exp(n_exp), .sum_zero(n_zero),
      .spec_nan(s1_nan), .spec_inf(s1_inf), .spec_sign(s1_isign),
      .spec_invalid(s1_inv), .res(r_res), .flags(r_flags)
   );

   // stage 2 registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_res   <= '0;
         out_flags <= '0;
      end else if (advance) begin
         out_valid <= s1_valid;
         if (s1_valid) begin
            out_res   <= r_res;
            out_flags <= r_flags;
         end
      end
   end

endmodule

// File: rtl/fpadd_sp_chk.sv
module fpadd_sp_chk #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  in_valid,
   input logic                  in_ready,
   input logic                  out_valid,
   input logic                  out_ready,
   input logic [EXP_W+FRAC_W:0] out_res,
   input logic [3:0]            out_flags
);
   localparam int DATA_W = 1 + EXP_W + FRAC_W;
   localparam logic [DATA_W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

   logic [EXP_W-1:0]  res_exp;
   logic [FRAC_W-1:0] res_frac;
   assign res_exp  = out_res[DATA_W-2:FRAC_W];
   assign res_frac = out_res[FRAC_W-1:0];

   // R1: two-edge latency when the edge after acceptance is not stalled
   p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) ##1 in_ready |=> out_valid);

   // R11: held output stays put
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_res) && $stable(out_flags)));

   // R11: no new operation while the output is held
   p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   // R8: overflow is inexact and gives infinity or the largest finite value
   p_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_flags[2]) |->
         (out_flags[0] && ((&res_exp && res_frac == '0) ||
                           (res_exp == {{(EXP_W-1){1'b1}}, 1'b0} && &res_frac))));

   // R9: invalid always returns the canonical quiet NaN
   p_invalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_flags[3]) |-> (out_res == QNAN));

   // R6: underflow marks an exact nonzero subnormal
   p_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_flags[1]) |-> (res_exp == '0 && res_frac != '0 && !out_flags[0]));

endmodule

bind fpadd_sp fpadd_sp_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .out_valid(out_valid), .out_ready(out_ready),
   .out_res(out_res), .out_flags(out_flags)
);

// File: tb/tb_fpadd_sp.sv
module tb_fpadd_sp;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_a = '0;
   logic [31:0] in_b = '0;
   logic        in_sub = 1'b0;
   logic [1:0]  in_rmode = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [31:0] out_res;
   logic [3:0]  out_flags;

   int n_checks = 0;
   int n_err    = 0;
   logic [31:0] seed = 32'h1234_5678;

   always #5ns clk = ~clk;

   fpadd_sp dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_a(in_a), .in_b(in_b), .in_sub(in_sub), .in_rmode(in_rmode),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_res(out_res), .out_flags(out_flags)
   );

   localparam logic [31:0] QNAN = 32'h7FC0_0000;

   // exact reference: both values as integers in units of 2^-149
   function automatic logic [35:0] ref_add(input logic [31:0] a, input logic [31:0] b,
                                           input logic sub, input logic [1:0] rm);
      logic [7:0]   ea, eb;
      logic [22:0]  fa, fb;
      logic         sa, sb, an, bn, asn, bsn, ai, bi, rs, up, toinf;
      logic [299:0] ma, mb, mag, keep, rem, half;
      logic [3:0]   fl;
      logic [31:0]  r;
      int           p, sh, ex;
      ea = a[30:23]; eb = b[30:23]; fa = a[22:0]; fb = b[22:0];
      sa = a[31]; sb = b[31] ^ sub;
      an = (ea == 8'hFF) && (fa != 0); bn = (eb == 8'hFF) && (fb != 0);
      asn = an && !fa[22]; bsn = bn && !fb[22];
      ai = (ea == 8'hFF) && (fa == 0); bi = (eb == 8'hFF) && (fb == 0);
      fl = '0; r = '0;
      if (an || bn) begin
         r = QNAN; fl[3] = asn | bsn;
      end else if (ai && bi && (sa != sb)) begin
         r = QNAN; fl[3] = 1'b1;
      end else if (ai) begin
         r = {sa, 8'hFF, 23'd0};
      end else if (bi) begin
         r = {sb, 8'hFF, 23'd0};
      end else begin
         ma = 300'({ea != 0, fa}) << ((ea == 0) ? 0 : int'(ea) - 1);
         mb = 300'({eb != 0, fb}) << ((eb == 0) ? 0 : int'(eb) - 1);
         if (sa == sb) begin mag = ma + mb; rs = sa; end
         else if (ma >= mb) begin mag = ma - mb; rs = sa; end
         else begin mag = mb - ma; rs = sb; end
         if (mag == 0) begin
            rs = (sa == sb) ? sa : (rm == 2'b10);
            r = {rs, 31'd0};
         end else begin
            p = 0;
            for (int i = 0; i < 300; i++) if (mag[i]) p = i;
            if (p <= 23) begin
               r = {rs, mag[30:0]};
               fl[1] = (p <= 22);
            end else begin
               sh = p - 23;
               keep = mag >> sh;
               rem = mag & ((300'd1 << sh) - 300'd1);
               half = 300'd1 << (sh - 1);
               case (rm)
                  2'b00:   up = (rem > half) || ((rem == half) && keep[0]);
                  2'b01:   up = 1'b0;
                  2'b10:   up = rs && (rem != 0);
                  default: up = !rs && (rem != 0);
               endcase
               keep = keep + 300'(up);
               if (keep[24]) begin keep = keep >> 1; sh = sh + 1; end
               ex = sh + 1;
               fl[0] = (rem != 0);
               if (ex >= 255) begin
                  fl[2] = 1'b1; fl[0] = 1'b1;
                  toinf = (rm == 2'b00) || (rm == 2'b11 && !rs) || (rm == 2'b10 && rs);
                  r = toinf ? {rs, 8'hFF, 23'd0} : {rs, 8'hFE, 23'h7FFFFF};
               end else begin
                  r = {rs, 8'(ex), keep[22:0]};
               end
            end
         end
      end
      return {fl, r};
   endfunction

   function automatic string tag_for(input logic [31:0] a, input logic [31:0] b,
                                     input logic [1:0] rm, input logic [35:0] e);
      if (e[30:23] == 8'hFF && e[22:0] != 0) return "R9";
      if (a[30:23] == 8'hFF || b[30:23] == 8'hFF) return "R10";
      if (e[34]) return "R8";
      if (e[33] || a[30:23] == 0 || b[30:23] == 0) return "R6";
      if (e[30:0] == 0) return "R7";
      if (rm != 0) return "R3";
      return "R2";
   endfunction

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [35:0] act, input logic [35:0] exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: got %h expected %h", rq, what, act, exp);
      end
   endtask

   // issue one operation with out_ready high and return its cycle count
   task automatic do_op(input logic [31:0] a, input logic [31:0] b, input logic sub,
                        input logic [1:0] rm, output logic [35:0] got, output int lat);
      @(negedge clk);
      in_a = a; in_b = b; in_sub = sub; in_rmode = rm; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      lat = 1;
      while (!out_valid) begin
         @(negedge clk);
         lat++;
      end
      got = {out_flags, out_res};
   endtask

   task automatic op_ref(input logic [31:0] a, input logic [31:0] b, input logic sub,
                         input logic [1:0] rm);
      logic [35:0] got, exp;
      int lat;
      do_op(a, b, sub, rm, got, lat);
      exp = ref_add(a, b, sub, rm);
      chk(got == exp, tag_for(a, b, rm, exp), $sformatf("%h %s %h rm%0d", a, sub ? "-" : "+", b, rm), got, exp);
   endtask

   task automatic op_lit(input logic [31:0] a, input logic [31:0] b, input logic sub,
                         input logic [1:0] rm, input logic [35:0] exp, input string rq);
      logic [35:0] got;
      int lat;
      do_op(a, b, sub, rm, got, lat);
      chk(got == exp, rq, $sformatf("%h %s %h rm%0d", a, sub ? "-" : "+", b, rm), got, exp);
      chk(ref_add(a, b, sub, rm) == exp, rq, "model agrees", ref_add(a, b, sub, rm), exp);
   endtask

   function automatic logic [31:0] next_rand(input logic [31:0] s);
      logic [31:0] x;
      x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   logic [31:0] grid [16];
   initial begin
      grid[0]  = 32'h0000_0000; grid[1]  = 32'h8000_0000;
      grid[2]  = 32'h0000_0001; grid[3]  = 32'h807F_FFFF;
      grid[4]  = 32'h0080_0000; grid[5]  = 32'h3F80_0000;
      grid[6]  = 32'hBF80_0001; grid[7]  = 32'h3380_0000;
      grid[8]  = 32'h40B8_0000; grid[9]  = 32'h3DCC_CCCD;
      grid[10] = 32'h7F7F_FFFF; grid[11] = 32'hFF7F_FFFF;
      grid[12] = 32'h7F80_0000; grid[13] = 32'hFF80_0000;
      grid[14] = 32'h7FC0_0000; grid[15] = 32'h7F80_0001;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

   initial begin
      logic [35:0] got;
      int lat;
      logic [31:0] ra, rb;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "reset out_valid", 36'(out_valid), 36'd0);
      chk(in_ready == 1'b1, "R1", "reset in_ready", 36'(in_ready), 36'd1);

      // R1 latency
      do_op(32'h3F80_0000, 32'h3F80_0000, 1'b0, 2'b00, got, lat);
      chk(lat == 2, "R1", "latency", 36'(lat), 36'd2);
      chk(got == {4'h0, 32'h4000_0000}, "R2", "1+1", got, {4'h0, 32'h4000_0000});

      // R2 check values
      op_lit(32'h4020_0000, 32'h4050_0000, 1'b0, 2'b00, {4'h0, 32'h40B8_0000}, "R2");
      op_lit(32'h3D4C_CCCD, 32'h3D4C_CCCD, 1'b0, 2'b00, {4'h0, 32'h3DCC_CCCD}, "R2");
      // R4 ties to even
      op_lit(32'h3F80_0000, 32'h3380_0000, 1'b0, 2'b00, {4'h1, 32'h3F80_0000}, "R4");
      op_lit(32'h3F80_0001, 32'h3380_0000, 1'b0, 2'b00, {4'h1, 32'h3F80_0002}, "R4");
      // R5 far operand
      op_lit(32'h7F00_0000, 32'h3F80_0000, 1'b0, 2'b00, {4'h1, 32'h7F00_0000}, "R5");
      op_lit(32'h7F00_0000, 32'h3F80_0000, 1'b0, 2'b11, {4'h1, 32'h7F00_0001}, "R5");
      // R3 directed modes on 1 + 2^-25 and its negative
      op_lit(32'h3F80_0000, 32'h3300_0000, 1'b0, 2'b01, {4'h1, 32'h3F80_0000}, "R3");
      op_lit(32'h3F80_0000, 32'h3300_0000, 1'b0, 2'b11, {4'h1, 32'h3F80_0001}, "R3");
      op_lit(32'h3F80_0000, 32'h3300_0000, 1'b0, 2'b10, {4'h1, 32'h3F80_0000}, "R3");
      op_lit(32'hBF80_0000, 32'h3300_0000, 1'b1, 2'b10, {4'h1, 32'hBF80_0001}, "R3");
      op_lit(32'hBF80_0000, 32'h3300_0000, 1'b1, 2'b11, {4'h1, 32'hBF80_0000}, "R3");
      // R7 cancellation sign
      op_lit(32'h3F80_0000, 32'h3F80_0000, 1'b1, 2'b00, {4'h0, 32'h0000_0000}, "R7");
      op_lit(32'h3F80_0000, 32'h3F80_0000, 1'b1, 2'b10, {4'h0, 32'h8000_0000}, "R7");
      op_lit(32'h8000_0000, 32'h0000_0000, 1'b1, 2'b00, {4'h0, 32'h8000_0000}, "R7");
      // R8 overflow
      op_lit(32'h7F7F_FFFF, 32'h7F7F_FFFF, 1'b0, 2'b00, {4'h5, 32'h7F80_0000}, "R8");
      op_lit(32'h7F7F_FFFF, 32'h7F7F_FFFF, 1'b0, 2'b01, {4'h5, 32'h7F7F_FFFF}, "R8");
      op_lit(32'hFF7F_FFFF, 32'hFF7F_FFFF, 1'b0, 2'b11, {4'h5, 32'hFF7F_FFFF}, "R8");
      op_lit(32'hFF7F_FFFF, 32'hFF7F_FFFF, 1'b0, 2'b10, {4'h5, 32'hFF80_0000}, "R8");
      // R6 subnormals
      op_lit(32'h0000_0001, 32'h0000_0001, 1'b0, 2'b00, {4'h2, 32'h0000_0002}, "R6");
      op_lit(32'h0040_0000, 32'h0040_0000, 1'b0, 2'b00, {4'h0, 32'h0080_0000}, "R6");
      op_lit(32'h0080_0000, 32'h0000_0001, 1'b1, 2'b00, {4'h2, 32'h007F_FFFF}, "R6");
      // R9 NaN
      op_lit(32'h7FC0_0000, 32'h3F80_0000, 1'b0, 2'b00, {4'h0, QNAN}, "R9");
      op_lit(32'h3F80_0000, 32'h7F80_0001, 1'b0, 2'b00, {4'h8, QNAN}, "R9");
      op_lit(32'h7F80_0000, 32'h7F80_0000, 1'b1, 2'b00, {4'h8, QNAN}, "R9");
      // R10 infinity
      op_lit(32'h7F80_0000, 32'h3F80_0000, 1'b1, 2'b00, {4'h0, 32'h7F80_0000}, "R10");
      op_lit(32'hFF80_0000, 32'h7F80_0000, 1'b1, 2'b01, {4'h0, 32'hFF80_0000}, "R10");

      // R11 backpressure
      @(negedge clk);
      out_ready = 1'b0;
      in_a = 32'h3F80_0000; in_b = 32'h3F80_0000; in_sub = 1'b0; in_rmode = 2'b00;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      while (!out_valid) @(negedge clk);
      in_a = 32'h4020_0000; in_b = 32'h4050_0000; in_valid = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(out_valid && out_res == 32'h4000_0000, "R11", "held result",
             {3'b0, out_valid, out_res}, {4'h1, 32'h4000_0000});
         chk(in_ready == 1'b0, "R11", "in_ready while held", 36'(in_ready), 36'd0);
      end
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      while (!out_valid) @(negedge clk);
      chk(out_res == 32'h40B8_0000, "R11", "operation offered during stall",
          36'(out_res), 36'h0_40B8_0000);

      // grid sweep
      for (int i = 0; i < 16; i++)
         for (int j = 0; j < 16; j++)
            for (int s = 0; s < 2; s++)
               for (int m = 0; m < 4; m++)
                  op_ref(grid[i], grid[j], 1'(s), 2'(m));

      // random pairs, half with nearby exponents
      for (int n = 0; n < 3000; n++) begin
         seed = next_rand(seed); ra = seed;
         seed = next_rand(seed); rb = seed;
         if (rb[0]) rb[30:23] = ra[30:23] + {{5{rb[3]}}, rb[3:1]};
         if (ra[30:23] == 8'hFF) ra[30] = 1'b0;
         if (rb[30:23] == 8'hFF) rb[30] = 1'b0;
         seed = next_rand(seed);
         op_ref(ra, rb, seed[4], seed[1:0]);
      end

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

endmodule